// File: doc/BRIEF.md
# I2C Register-Pointer Target

This block is an I2C target that sits on a shared two-wire bus and gives a master access to a small byte-wide register array. It samples SCL and SDA on the system clock through synchronizers and detects START, repeated START and STOP conditions from edges of those sampled lines. The first byte after any START carries a 7-bit target address and a direction flag. When the address matches, the block acknowledges the byte and moves into a write or a read transfer. When the address does not match, the block stays silent until the next START.

The block holds an internal address counter that persists between transfers. In a write transfer, the byte after the address byte loads the counter. Each data byte after that is stored at the counter location, and the counter then advances. A read transfer has no address byte of its own, so it returns data from wherever the counter currently points. A random read is done with a short write that only sets the counter, followed by a repeated START in the read direction.

SDA is only ever pulled low, through an open-drain enable output. A host-side write port can also load the register array directly.

Top module: `i2c_regptr_target`

## Requirements
- R1: After reset, SDA is released (`sda_oe` = 0), every register reads 0x00, and the address counter is 0.
- R2: The block acknowledges a first byte whose bits 7:1 equal 7'b0110100, by driving SDA low in the ninth clock. Bit 0 of that byte selects the direction: 0 is write, 1 is read. For any other address, the block never drives SDA and never writes the array until the next START.
- R3: In a write transfer, the second byte, taken modulo the register depth, loads the address counter and is acknowledged. Each later byte is stored at the counter and then advances the counter by one.
- R4: A write transfer accepts and acknowledges at most 8 data bytes after the memory address byte. Later data bytes get NACK (SDA high in the ninth clock) and are not stored.
- R5: A read transfer returns bytes from the current counter value. The counter is left by earlier transfers, and the counter advances after each byte is read.
- R6: A write-direction address byte, then a memory address byte, then a repeated START, then a read-direction address byte, returns data starting at the newly loaded address.
- R7: The address counter wraps from the last register to register 0, on writes and on reads.
- R8: Read data goes out MSB first. SDA changes only while SCL is low. A master NACK in the ninth clock ends the read, and SDA then stays released until the next START.
- R9: A STOP or a START in the middle of a byte abandons that byte: nothing is stored and SDA is released. A START restarts address reception.
- R10: A pulse on `ext_we` writes `ext_wdata` to register `ext_addr`. The new value is visible to later I2C reads.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; the bus lines are oversampled with it |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_in | input | 1 | Bus clock line as seen at the pad |
| sda_in | input | 1 | Bus data line as seen at the pad |
| sda_oe | output | 1 | When 1, the pad pulls SDA low |
| ext_we | input | 1 | Host-side register write strobe |
| ext_addr | input | AW (4) | Host-side register index |
| ext_wdata | input | 8 | Host-side write data |

## Verification
The bench goes after the write burst limit by sending ten data bytes. A design that counted the limit off by one would acknowledge or store a ninth byte, and that byte would appear at the wrapped address 0. Reads that cross the top register and writes that straddle it check the counter wrap; a counter that saturated or overflowed into unused bits would return the wrong bytes. Foreign-address traffic, and STOP or repeated START conditions cut into the middle of a byte, are each followed by a read of the registers they could have hit. A block that kept listening, or that committed a partial byte, would show changed data there or an ACK where none belongs. After a master NACK, the bench clocks extra bits to catch a target that keeps driving data.

// File: rtl/i2c_rp_pkg.sv
package i2c_rp_pkg;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_DEV,
    ST_DEV_ACK,
    ST_MEM,
    ST_MEM_ACK,
    ST_WR,
    ST_WR_ACK,
    ST_RD,
    ST_RD_ACK,
    ST_IGNORE
  } rp_state_e;

  // Address byte carries the target address in bits 7:1.
  function automatic logic dev_hit(input logic [7:0] b, input logic [6:0] dev);
    return b[7:1] == dev;
  endfunction

  // Direction flag: 1 selects a read transfer.
  function automatic logic dir_is_read(input logic [7:0] b);
    return b[0];
  endfunction

  // Counter advance with wrap at the array depth.
  function automatic int unsigned step_wrap(input int unsigned p, input int unsigned depth);
    return (p + 1 >= depth) ? 0 : p + 1;
  endfunction

  // Memory address byte folded into the array range.
  function automatic int unsigned fold_addr(input logic [7:0] b, input int unsigned depth);
    return 32'(b) % depth;
  endfunction

endpackage

// File: rtl/i2c_rp_sync.sv
module i2c_rp_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_in,
  input  logic sda_in,
  output logic scl_s,
  output logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_evt,
  output logic stop_evt
);

  localparam int LINES = 2;

  logic [LINES-1:0] raw;
  logic [LINES-1:0] now_v;
  logic [LINES-1:0] prev_q;

  assign raw = {scl_in, sda_in};

  for (genvar g = 0; g < LINES; g++) begin : g_line
    logic [STAGES-1:0] chain;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain <= '1;
      else        chain <= {chain[STAGES-2:0], raw[g]};
    end
    assign now_v[g] = chain[STAGES-1];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= '1;
    else        prev_q <= now_v;
  end

  assign scl_s     = now_v[1];
  assign sda_s     = now_v[0];
  assign scl_rise  = now_v[1] & ~prev_q[1];
  assign scl_fall  = ~now_v[1] & prev_q[1];
  assign start_evt = now_v[1] & prev_q[1] & prev_q[0] & ~now_v[0];
  assign stop_evt  = now_v[1] & prev_q[1] & ~prev_q[0] & now_v[0];

endmodule

// File: rtl/i2c_rp_regfile.sv
module i2c_rp_regfile #(
  parameter int DEPTH  = 16,
  parameter int AW     = 4,
  parameter bit EXT_WR = 1'b1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          bus_we,
  input  logic [AW-1:0] bus_addr,
  input  logic [7:0]    bus_wdata,
  input  logic          ext_we,
  input  logic [AW-1:0] ext_addr,
  input  logic [7:0]    ext_wdata,
  input  logic [AW-1:0] rd_addr,
  output logic [7:0]    rd_data
);

  logic [7:0]    mem [DEPTH];
  logic          we_sel;
  logic [AW-1:0] addr_sel;
  logic [7:0]    data_sel;

  if (EXT_WR) begin : g_ext
    // Host port wins a same-cycle collision.
    assign we_sel   = ext_we | bus_we;
    assign addr_sel = ext_we ? ext_addr  : bus_addr;
    assign data_sel = ext_we ? ext_wdata : bus_wdata;
  end else begin : g_noext
    logic ext_unused;
    assign ext_unused = ^{ext_we, ext_addr, ext_wdata};
    assign we_sel   = bus_we;
    assign addr_sel = bus_addr;
    assign data_sel = bus_wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= 8'h00;
    end else if (we_sel) begin
      mem[addr_sel] <= data_sel;
    end
  end

  assign rd_data = mem[rd_addr];

endmodule

// File: rtl/i2c_rp_ctrl.sv
module i2c_rp_ctrl
  import i2c_rp_pkg::*;
#(
  parameter logic [6:0] DEV_ADDR  = 7'h34,
  parameter int         DEPTH     = 16,
  parameter int         MAX_BURST = 8,
  parameter int         AW        = 4,
  parameter int         BW        = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          sda_s,
  input  logic          scl_rise,
  input  logic          scl_fall,
  input  logic          start_evt,
  input  logic          stop_evt,
  input  logic [7:0]    rd_data,
  output logic          sda_oe,
  output logic [AW-1:0] ptr,
  output logic          wr_stb,
  output logic [AW-1:0] wr_addr,
  output logic [7:0]    wr_data,
  output logic [BW-1:0] burst_cnt,
  output logic          ignoring,
  output logic          bus_idle
);

  rp_state_e  st;
  logic [2:0] cnt;
  logic [7:0] sh;
  logic       byte_full;
  logic       rd_dir;
  logic       m_ack;
  logic       rx_state;

  assign rx_state = (st == ST_DEV) || (st == ST_MEM) || (st == ST_WR);
  assign ignoring = (st == ST_IGNORE);
  assign bus_idle = (st == ST_IDLE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st        <= ST_IDLE;
      cnt       <= 3'd0;
      sh        <= 8'h00;
      byte_full <= 1'b0;
      rd_dir    <= 1'b0;
      m_ack     <= 1'b0;
      sda_oe    <= 1'b0;
      ptr       <= '0;
      wr_stb    <= 1'b0;
      wr_addr   <= '0;
      wr_data   <= 8'h00;
      burst_cnt <= '0;
    end else begin
      wr_stb <= 1'b0;
      if (start_evt) begin
        st        <= ST_DEV;
        cnt       <= 3'd0;
        byte_full <= 1'b0;
        sda_oe    <= 1'b0;
        burst_cnt <= '0;
      end else if (stop_evt) begin
        st        <= ST_IDLE;
        byte_full <= 1'b0;
        sda_oe    <= 1'b0;
      end else if (rx_state) begin
        if (scl_rise) begin
          sh  <= {sh[6:0], sda_s};
          cnt <= cnt + 3'd1;
          if (cnt == 3'd7) byte_full <= 1'b1;
        end else if (scl_fall && byte_full) begin
          byte_full <= 1'b0;
          case (st)
            ST_DEV: begin
              if (dev_hit(sh, DEV_ADDR)) begin
                rd_dir <= dir_is_read(sh);
                sda_oe <= 1'b1;
                st     <= ST_DEV_ACK;
              end else begin
                st <= ST_IGNORE;
              end
            end
            ST_MEM: begin
              ptr    <= AW'(fold_addr(sh, DEPTH));
              sda_oe <= 1'b1;
              st     <= ST_MEM_ACK;
            end
            default: begin
              if (burst_cnt < BW'(MAX_BURST)) begin
                wr_stb    <= 1'b1;
                wr_addr   <= ptr;
                wr_data   <= sh;
                ptr       <= AW'(step_wrap(32'(ptr), DEPTH));
                burst_cnt <= burst_cnt + BW'(1);
                sda_oe    <= 1'b1;
              end else begin
                sda_oe <= 1'b0;
              end
              st <= ST_WR_ACK;
            end
          endcase
        end
      end else begin
        case (st)
          ST_DEV_ACK: begin
            if (scl_fall) begin
              cnt <= 3'd0;
              if (rd_dir) begin
                sh     <= rd_data;
                sda_oe <= ~rd_data[7];
                st     <= ST_RD;
              end else begin
                sda_oe <= 1'b0;
                st     <= ST_MEM;
              end
            end
          end
          ST_MEM_ACK, ST_WR_ACK: begin
            if (scl_fall) begin
              sda_oe <= 1'b0;
              cnt    <= 3'd0;
              st     <= ST_WR;
            end
          end
          ST_RD: begin
            if (scl_fall) begin
              if (cnt == 3'd7) begin
                sda_oe <= 1'b0;
                ptr    <= AW'(step_wrap(32'(ptr), DEPTH));
                st     <= ST_RD_ACK;
              end else begin
                sh     <= {sh[6:0], 1'b0};
                sda_oe <= ~sh[6];
                cnt    <= cnt + 3'd1;
              end
            end
          end
          ST_RD_ACK: begin
            if (scl_rise) begin
              m_ack <= ~sda_s;
            end else if (scl_fall) begin
              if (m_ack) begin
                sh     <= rd_data;
                sda_oe <= ~rd_data[7];
                cnt    <= 3'd0;
                st     <= ST_RD;
              end else begin
                st <= ST_IGNORE;
              end
            end
          end
          default: ;
        endcase
      end
    end
  end

endmodule

// File: rtl/i2c_regptr_target.sv
module i2c_regptr_target #(
  parameter logic [6:0] DEV_ADDR    = 7'b0110100,
  parameter int         REG_DEPTH   = 16,
  parameter int         MAX_BURST   = 8,
  parameter int         SYNC_STAGES = 2,
  parameter bit         EXT_WR_EN   = 1'b1,
  localparam int        AW          = $clog2(REG_DEPTH),
  localparam int        BW          = $clog2(MAX_BURST + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          scl_in,
  input  logic          sda_in,
  output logic          sda_oe,
  input  logic          ext_we,
  input  logic [AW-1:0] ext_addr,
  input  logic [7:0]    ext_wdata
);

  logic          scl_s, sda_s, scl_rise, scl_fall, start_evt, stop_evt;
  logic [7:0]    rd_data;
  logic [AW-1:0] ptr;
  logic          wr_stb;
  logic [AW-1:0] wr_addr;
  logic [7:0]    wr_data;
  logic [BW-1:0] burst_cnt;
  logic          ignoring;
  logic          bus_idle;

  i2c_rp_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .scl_in(scl_in), .sda_in(sda_in),
    .scl_s(scl_s), .sda_s(sda_s), .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_evt(start_evt), .stop_evt(stop_evt)
  );

  i2c_rp_ctrl #(
    .DEV_ADDR(DEV_ADDR), .DEPTH(REG_DEPTH), .MAX_BURST(MAX_BURST), .AW(AW), .BW(BW)
  ) u_ctrl (
    .clk(clk), .rst_n(rst_n), .sda_s(sda_s), .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_evt(start_evt), .stop_evt(stop_evt), .rd_data(rd_data),
    .sda_oe(sda_oe), .ptr(ptr), .wr_stb(wr_stb), .wr_addr(wr_addr), .wr_data(wr_data),
    .burst_cnt(burst_cnt), .ignoring(ignoring), .bus_idle(bus_idle)
  );

  i2c_rp_regfile #(.DEPTH(REG_DEPTH), .AW(AW), .EXT_WR(EXT_WR_EN)) u_regs (
    .clk(clk), .rst_n(rst_n), .bus_we(wr_stb), .bus_addr(wr_addr), .bus_wdata(wr_data),
    .ext_we(ext_we), .ext_addr(ext_addr), .ext_wdata(ext_wdata),
    .rd_addr(ptr), .rd_data(rd_data)
  );

endmodule

// File: rtl/i2c_rp_checker.sv
module i2c_rp_checker #(
  parameter int MAX_BURST = 8,
  parameter int BW        = 4
) (
  input logic          clk,
  input logic          rst_n,
  input logic          scl_s,
  input logic          sda_oe,
  input logic          ignoring,
  input logic          bus_idle,
  input logic          start_evt,
  input logic          stop_evt,
  input logic          wr_stb,
  input logic [BW-1:0] burst_cnt
);

  assert_reset_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (!sda_oe && bus_idle));

  assert_silent_ignore_R2: assert property (@(posedge clk) disable iff (!rst_n)
    ignoring |-> !sda_oe);

  assert_no_overflow_R4: assert property (@(posedge clk) disable iff (!rst_n)
    wr_stb |-> (burst_cnt != '0 && burst_cnt <= BW'(MAX_BURST)));

  assert_sda_scl_low_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (sda_oe != $past(sda_oe)) |-> !$past(scl_s));

  assert_start_release_R9: assert property (@(posedge clk) disable iff (!rst_n)
    start_evt |=> (!sda_oe && !bus_idle));

  assert_stop_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
    stop_evt |=> (!sda_oe && bus_idle));

endmodule

bind i2c_regptr_target i2c_rp_checker #(.MAX_BURST(MAX_BURST), .BW(BW)) u_chk (
  .clk(clk), .rst_n(rst_n), .scl_s(scl_s), .sda_oe(sda_oe), .ignoring(ignoring),
  .bus_idle(bus_idle), .start_evt(start_evt), .stop_evt(stop_evt),
  .wr_stb(wr_stb), .burst_cnt(burst_cnt)
);

// File: tb/i2c_regptr_target_test.sv
module i2c_regptr_target_test;

  localparam int Q = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       m_scl = 1'b1;
  logic       m_sda = 1'b1;
  logic       ext_we = 1'b0;
  logic [3:0] ext_addr = 4'd0;
  logic [7:0] ext_wdata = 8'h00;
  logic       sda_oe;
  logic       sda_line;
  int         checks = 0;
  int         fails = 0;

  assign sda_line = m_sda & ~sda_oe;

  always #4 clk = ~clk;

  i2c_regptr_target uut (
    .clk(clk), .rst_n(rst_n), .scl_in(m_scl), .sda_in(sda_line), .sda_oe(sda_oe),
    .ext_we(ext_we), .ext_addr(ext_addr), .ext_wdata(ext_wdata)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic wq();
    repeat (Q) @(negedge clk);
  endtask

  task automatic bus_start();
    m_sda = 1'b1; wq(); m_scl = 1'b1; wq(); m_sda = 1'b0; wq(); m_scl = 1'b0; wq();
  endtask

  task automatic bus_stop();
    m_sda = 1'b0; wq(); m_scl = 1'b1; wq(); m_sda = 1'b1; wq();
  endtask

  task automatic put_bit(input bit b);
    m_sda = b; wq(); m_scl = 1'b1; wq(); wq(); m_scl = 1'b0; wq();
  endtask

  task automatic get_bit(output bit b);
    m_sda = 1'b1; wq(); m_scl = 1'b1; wq(); b = sda_line; wq(); m_scl = 1'b0; wq();
  endtask

  task automatic put_byte(input logic [7:0] v, output bit acked);
    bit a;
    for (int i = 7; i >= 0; i--) put_bit(v[i]);
    get_bit(a);
    acked = ~a;
  endtask

  task automatic get_byte(input bit give_ack, output logic [7:0] v);
    bit b;
    for (int i = 7; i >= 0; i--) begin
      get_bit(b);
      v[i] = b;
    end
    put_bit(~give_ack);
  endtask

  // Point the counter with a dummy write, then turn round into a read.
  task automatic aim_read(input logic [7:0] where, input string req);
    bit a;
    bus_start();
    put_byte(8'h68, a); chk(a, req, a, 1);
    put_byte(where, a); chk(a, req, a, 1);
    bus_start();
    put_byte(8'h69, a); chk(a, req, a, 1);
  endtask

  task automatic expect_bytes(input int n, input logic [7:0] first, input logic [7:0] step,
                              input string req);
    logic [7:0] v;
    for (int i = 0; i < n; i++) begin
      get_byte(i != n - 1, v);
      chk(v == 8'(first + step * 8'(i)), req, v, 8'(first + step * 8'(i)));
    end
  endtask

  task automatic t_reset();
    chk(sda_oe == 1'b0, "R1 sda released after reset", sda_oe, 0);
  endtask

  task automatic t_read_after_reset();
    bit a; logic [7:0] v;
    bus_start();
    put_byte(8'h69, a); chk(a, "R2 read address acked", a, 1);
    get_byte(1'b0, v);  chk(v == 8'h00, "R1 R5 reg0 from reset counter", v, 0);
    bus_stop();
    chk(sda_oe == 1'b0, "R8 released after stop", sda_oe, 0);
  endtask

  task automatic t_ext_write();
    @(negedge clk); ext_we = 1'b1; ext_addr = 4'd5; ext_wdata = 8'h5C;
    @(negedge clk); ext_addr = 4'd6; ext_wdata = 8'h66;
    @(negedge clk); ext_we = 1'b0;
  endtask

  task automatic t_burst_write();
    bit a;
    bus_start();
    put_byte(8'h68, a); chk(a, "R2 write address acked", a, 1);
    put_byte(8'h02, a); chk(a, "R3 memory address acked", a, 1);
    for (int i = 0; i < 3; i++) begin
      put_byte(8'hA0 + 8'(i), a); chk(a, "R3 data acked", a, 1);
    end
    bus_stop();
  endtask

  task automatic t_current_read();
    bit a; logic [7:0] v;
    bus_start();
    put_byte(8'h69, a); chk(a, "R5 read address acked", a, 1);
    get_byte(1'b1, v); chk(v == 8'h5C, "R5 R10 read at retained counter", v, 8'h5C);
    get_byte(1'b0, v); chk(v == 8'h66, "R5 R10 counter advanced", v, 8'h66);
    bus_stop();
  endtask

  task automatic t_random_read();
    logic [7:0] v;
    aim_read(8'h02, "R6 dummy write");
    expect_bytes(3, 8'hA0, 8'h01, "R3 R6 random read data");
    get_byte(1'b0, v);
    chk(v == 8'hFF, "R8 silent after master NACK", v, 8'hFF);
    bus_stop();
  endtask

  task automatic t_burst_cap();
    bit a;
    bus_start();
    put_byte(8'h68, a);
    put_byte(8'h08, a);
    for (int i = 0; i < 10; i++) begin
      put_byte(8'h10 + 8'(i), a);
      chk(a == (i < 8), "R4 ack only first eight", a, int'(i < 8));
    end
    bus_stop();
    aim_read(8'h08, "R4 readback setup");
    expect_bytes(8, 8'h10, 8'h01, "R4 stored burst");
    bus_stop();
    aim_read(8'h00, "R4 readback setup");
    expect_bytes(1, 8'h00, 8'h00, "R4 R7 ninth byte not stored at wrap");
    bus_stop();
  endtask

  task automatic t_wrap();
    bit a;
    bus_start();
    put_byte(8'h68, a);
    put_byte(8'h0E, a);
    for (int i = 0; i < 3; i++) begin
      put_byte(8'hE1 + 8'(i), a); chk(a, "R7 wrap write acked", a, 1);
    end
    bus_stop();
    aim_read(8'h0E, "R7 readback setup");
    expect_bytes(3, 8'hE1, 8'h01, "R7 read across wrap");
    bus_stop();
  endtask

  task automatic t_mismatch();
    bit a; logic [7:0] v;
    bus_start();
    put_byte(8'h6A, a); chk(!a, "R2 foreign address not acked", a, 0);
    put_byte(8'h03, a); chk(!a, "R2 ignored byte not acked", a, 0);
    put_byte(8'h99, a); chk(!a, "R2 ignored data not acked", a, 0);
    bus_stop();
    bus_start();
    put_byte(8'h6B, a); chk(!a, "R2 foreign read not acked", a, 0);
    get_byte(1'b0, v);  chk(v == 8'hFF, "R2 foreign read undriven", v, 8'hFF);
    bus_stop();
    aim_read(8'h03, "R2 readback setup");
    expect_bytes(1, 8'hA1, 8'h00, "R2 register untouched");
    bus_stop();
  endtask

  task automatic t_abort();
    bit a;
    bus_start();
    put_byte(8'h68, a);
    put_byte(8'h04, a);
    for (int i = 0; i < 4; i++) put_bit(1'b0);
    bus_stop();
    chk(sda_oe == 1'b0, "R9 released after mid-byte stop", sda_oe, 0);
    aim_read(8'h04, "R9 readback setup");
    expect_bytes(1, 8'hA2, 8'h00, "R9 partial byte not stored");
    bus_stop();
    bus_start();
    put_byte(8'h68, a);
    put_byte(8'h06, a);
    for (int i = 0; i < 3; i++) put_bit(1'b1);
    bus_start();
    put_byte(8'h69, a); chk(a, "R9 restart mid-byte acked", a, 1);
    expect_bytes(1, 8'h66, 8'h00, "R9 R6 counter kept after restart");
    bus_stop();
  endtask

  task automatic t_fold();
    aim_read(8'h13, "R3 folded address setup");
    expect_bytes(1, 8'hA1, 8'h00, "R3 address byte modulo depth");
    bus_stop();
  endtask

  initial begin
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    t_reset();
    t_read_after_reset();
    t_ext_write();
    t_burst_write();
    t_current_read();
    t_random_read();
    t_burst_cap();
    t_wrap();
    t_mismatch();
    t_abort();
    t_fold();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog expired actual=0x0 expected=0x1");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule